// File: doc/BRIEF.md
# Store-and-Forward Transmit Frame Buffer

This block sits between a byte-wide frame source and the transmit client port of an Ethernet MAC. Both sides run on one clock. The source pushes bytes tagged with start-of-frame and end-of-frame markers. The block writes each frame into a 4096-byte buffer. A frame becomes visible to the MAC side only after its end-of-frame byte has been stored, so a frame is never started toward the MAC before it is complete.

The MAC side works as follows. When at least one complete frame is stored, the block drives the frame's first byte with `mac_valid` and holds it until the MAC pulses `mac_ack`. From the next cycle on, the rest of the frame is streamed out one byte per cycle with no gaps. `mac_valid` then drops for at least one cycle before the next frame is offered.

Back-pressure rules for the source stream:
- `src_ready` is held high at all times, and a byte is taken on every clock edge where `src_valid` is high.
- If a frame does not fit in the free space, the block still takes the rest of that frame from the source. It then discards the whole frame and rolls the write pointer back to where that frame started.
- Each discarded frame pulses `drop_flag` and increments a 4-bit wrapping counter.

The buffer occupancy, counting a frame that is still being written, is reported in 256-byte units. Correct operation is required only for frames of 14 bytes or more.

Top module: `tx_frame_buffer`

## Requirements
- R1: After reset, `mac_valid` is 0, `fill_units` is 0, `drop_count` is 0 and `drop_flag` is 0.
- R2: While a frame is being written into an empty buffer, `mac_valid` stays 0. If the end-of-frame byte is taken at clock edge E, `mac_valid` is still 0 after E and becomes 1 after edge E+1.
- R3: A frame that does not fit in the free space is discarded and never offered to the MAC. `drop_flag` is 1 for exactly the one cycle after the edge that takes that frame's end-of-frame byte, and `drop_count` increments at that same edge, wrapping from 15 to 0.
- R4: After a discard, `fill_units` returns to the value it had before the discarded frame began. Frames already stored, and frames written afterwards, are delivered intact.
- R5: While `mac_valid` is 1 and no `mac_ack` has been given for the current frame, `mac_data` holds the frame's first byte and `mac_valid` stays 1.
- R6: On the clock edge where `mac_ack` is high, the first byte is consumed. From the next cycle on, bytes 1 to N-1 of the frame appear on `mac_data` in order, one per cycle, with `mac_valid` high throughout. `mac_ack` is ignored during this burst.
- R7: In the cycle after the last byte of a frame is shown, `mac_valid` is 0. If another complete frame is stored, its first byte appears with `mac_valid` in the cycle after that.
- R8: `fill_units` equals floor(B/256), where B is the number of bytes written and not yet sent. B includes the bytes of a frame that is still being written.
- R9: `src_ready` is 1 in every cycle after reset, including while an oversized frame is being taken.
- R10: Several stored frames are delivered to the MAC in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_data | input | 8 | Source byte |
| src_sof | input | 1 | Byte is the first of a frame |
| src_eof | input | 1 | Byte is the last of a frame |
| src_valid | input | 1 | Source byte present |
| src_ready | output | 1 | Block accepts a byte (always 1) |
| mac_data | output | 8 | Byte offered to the MAC |
| mac_valid | output | 1 | A frame is being offered or streamed |
| mac_ack | input | 1 | MAC accepts the first byte and starts the burst |
| drop_flag | output | 1 | One-cycle pulse when a frame is discarded |
| drop_count | output | 4 | Wrapping count of discarded frames |
| fill_units | output | 5 | Occupancy in 256-byte units |

## Verification
Frames of 14 to 1000 bytes are written into an empty buffer, using different acknowledge delays. These runs separate the store-then-release latency, the held first byte and the gap-free burst. Two frames are queued back to back to confirm that the first byte of the second frame follows the one-cycle gap. Oversized frames are sent into an empty buffer and into a partly filled one. These runs show that the source is never stalled, that the write pointer rolls back to the frame start without disturbing an earlier stored frame, and that the 4-bit drop counter wraps. A long frame is watched while it is being written, to show that the fill level counts partially written bytes.

// File: rtl/tx_frame_buffer_pkg.sv
package tx_frame_buffer_pkg;
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } buf_word_t;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SHOW  = 2'd1,
    RD_BURST = 2'd2
  } rd_state_t;
endpackage

// File: rtl/tx_frame_store.sv
module tx_frame_store
  import tx_frame_buffer_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  buf_word_t         wr_word,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output buf_word_t         rd_word
);
  buf_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/tx_frame_writer.sv
module tx_frame_writer
  import tx_frame_buffer_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_valid,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output buf_word_t         mem_word,
  output logic              commit,
  output logic              discard,
  output logic [PTR_W-1:0]  used
);
  localparam logic [PTR_W-1:0] FULL_USED = PTR_W'(DEPTH);

  logic [PTR_W-1:0] start_q, start_d, cur_q, cur_d, addr_eff, used_eff;
  logic             drop_q, drop_d, room;

  assign addr_eff = in_sof ? start_q : cur_q;
  assign used_eff = addr_eff - rd_ptr;
  assign room     = (used_eff != FULL_USED);
  assign used     = cur_q - rd_ptr;
  assign mem_addr = addr_eff[ADDR_W-1:0];
  assign mem_word = '{last: in_eof, data: in_data};

  always_comb begin
    start_d = start_q;
    cur_d   = cur_q;
    drop_d  = drop_q;
    mem_we  = 1'b0;
    commit  = 1'b0;
    discard = 1'b0;
    if (in_valid) begin
      if (drop_q) begin
        if (in_eof) begin
          drop_d  = 1'b0;
          discard = 1'b1;
        end
      end else if (!room) begin
        cur_d = start_q;
        if (in_eof) discard = 1'b1;
        else        drop_d  = 1'b1;
      end else begin
        mem_we = 1'b1;
        cur_d  = addr_eff + 1'b1;
        if (in_eof) begin
          start_d = addr_eff + 1'b1;
          commit  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
      drop_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      cur_q   <= cur_d;
      drop_q  <= drop_d;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= FULL_USED); // R8
  AST_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (cur_q == start_q) && !drop_q); // R4
endmodule

// File: rtl/tx_frame_reader.sv
module tx_frame_reader
  import tx_frame_buffer_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frames_avail,
  input  buf_word_t         rd_word,
  input  logic              mac_ack,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [7:0]        mac_data,
  output logic              mac_valid,
  output logic              frame_done
);
  rd_state_t        state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  assign rd_ptr    = ptr_q;
  assign rd_addr   = ptr_q[ADDR_W-1:0];
  assign mac_data  = rd_word.data;
  assign mac_valid = (state_q != RD_IDLE);

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    frame_done = 1'b0;
    unique case (state_q)
      RD_IDLE: if (frames_avail) state_d = RD_SHOW;
      RD_SHOW: if (mac_ack) begin
        ptr_d = ptr_q + 1'b1;
        if (rd_word.last) begin
          frame_done = 1'b1;
          state_d    = RD_IDLE;
        end else begin
          state_d = RD_BURST;
        end
      end
      RD_BURST: begin
        ptr_d = ptr_q + 1'b1;
        if (rd_word.last) begin
          frame_done = 1'b1;
          state_d    = RD_IDLE;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  AST_START_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_valid) |-> $past(frames_avail)); // R2
  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RD_SHOW) && !mac_ack |=> mac_valid && $stable(mac_data) && $stable(ptr_q)); // R5
  AST_BURST_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RD_BURST) && !rd_word.last |=> mac_valid); // R6
  AST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !mac_valid); // R7
endmodule

// File: rtl/tx_frame_buffer.sv
module tx_frame_buffer
  import tx_frame_buffer_pkg::*;
#(
  parameter int DEPTH      = 4096,
  parameter int UNIT_BYTES = 256,
  parameter int DROP_W     = 4,
  parameter int ADDR_W     = $clog2(DEPTH),
  parameter int PTR_W      = ADDR_W + 1,
  parameter int FILL_W     = PTR_W - $clog2(UNIT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        src_data,
  input  logic              src_sof,
  input  logic              src_eof,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [7:0]        mac_data,
  output logic              mac_valid,
  input  logic              mac_ack,
  output logic              drop_flag,
  output logic [DROP_W-1:0] drop_count,
  output logic [FILL_W-1:0] fill_units
);
  localparam int UNIT_W = $clog2(UNIT_BYTES);

  logic              mem_we, commit, discard, frame_done;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PTR_W-1:0]  rd_ptr, used, frame_cnt;
  buf_word_t         wr_word, rd_word;

  assign src_ready  = 1'b1;
  assign fill_units = used[PTR_W-1:UNIT_W];

  tx_frame_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_word(wr_word), .wr_en(mem_we), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  tx_frame_writer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .in_data(src_data), .in_sof(src_sof),
    .in_eof(src_eof), .in_valid(src_valid), .rd_ptr(rd_ptr),
    .mem_we(mem_we), .mem_addr(wr_addr), .mem_word(wr_word),
    .commit(commit), .discard(discard), .used(used)
  );

  tx_frame_reader #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .frames_avail(frame_cnt != '0),
    .rd_word(rd_word), .mac_ack(mac_ack), .rd_addr(rd_addr),
    .rd_ptr(rd_ptr), .mac_data(mac_data), .mac_valid(mac_valid),
    .frame_done(frame_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt  <= '0;
      drop_flag  <= 1'b0;
      drop_count <= '0;
    end else begin
      frame_cnt  <= frame_cnt + PTR_W'(commit) - PTR_W'(frame_done);
      drop_flag  <= discard;
      drop_count <= drop_count + DROP_W'(discard);
    end
  end

  AST_FRAME_CNT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_cnt != '0)); // R10
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |=> !drop_flag || $changed(drop_count)); // R3
endmodule

// File: tb/tx_frame_buffer_test.sv
`timescale 1ns/1ps
module tx_frame_buffer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_data = '0;
  logic       src_sof = 1'b0, src_eof = 1'b0, src_valid = 1'b0;
  logic       src_ready;
  logic [7:0] mac_data;
  logic       mac_valid;
  logic       mac_ack = 1'b0;
  logic       drop_flag;
  logic [3:0] drop_count;
  logic [4:0] fill_units;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tx_frame_buffer uut (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_sof(src_sof),
    .src_eof(src_eof), .src_valid(src_valid), .src_ready(src_ready),
    .mac_data(mac_data), .mac_valid(mac_valid), .mac_ack(mac_ack),
    .drop_flag(drop_flag), .drop_count(drop_count), .fill_units(fill_units)
  );

  // Vector table: frame length, pattern seed, cycles the acknowledge is withheld
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{14, 1, 0}, '{15, 2, 3}, '{64, 3, 1}, '{255, 4, 5}, '{256, 5, 2}, '{1000, 6, 7}
  };

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 13 + i * 7 + (i >> 8));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives one frame, one byte per cycle; returns at the negedge after the eof edge.
  task automatic send_frame(int len, int seed, output int valid_seen, output int not_ready);
    valid_seen = 0;
    not_ready = 0;
    for (int i = 0; i < len; i++) begin
      src_data  = pat(seed, i);
      src_sof   = (i == 0);
      src_eof   = (i == len - 1);
      src_valid = 1'b1;
      if (mac_valid) valid_seen++;
      if (!src_ready) not_ready++;
      @(negedge clk);
    end
    src_valid = 1'b0;
    src_sof   = 1'b0;
    src_eof   = 1'b0;
  endtask

  // Receives one frame; ends at the negedge after the last byte, and checks the gap.
  task automatic recv_frame(int len, int seed, int hold, output int waited);
    int bad_i;
    logic [7:0] bad_v;
    bit hold_ok;
    waited = 0;
    while (!mac_valid && waited < 10000) begin
      @(negedge clk);
      waited++;
    end
    chk(mac_valid && mac_data == pat(seed, 0), "R5 first byte offered", int'(mac_data), int'(pat(seed, 0)));
    hold_ok = 1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!mac_valid || mac_data != pat(seed, 0)) hold_ok = 0;
    end
    chk(hold_ok, "R5 first byte held until ack", int'(mac_data), int'(pat(seed, 0)));
    mac_ack = 1'b1;
    @(negedge clk);
    mac_ack = 1'b0;
    bad_i = -1;
    bad_v = '0;
    for (int i = 1; i < len; i++) begin
      if (bad_i < 0 && (!mac_valid || mac_data != pat(seed, i))) begin
        bad_i = i;
        bad_v = mac_valid ? mac_data : 8'hxx;
      end
      @(negedge clk);
    end
    chk(bad_i < 0, "R6 burst bytes in order",
        int'(bad_v), (bad_i < 0) ? 0 : int'(pat(seed, bad_i)));
    chk(!mac_valid, "R7 valid low after last byte", int'(mac_valid), 0);
  endtask

  initial begin
    int vs, nr, w;
    repeat (3) @(negedge clk);
    // R1 / R9: reset state
    chk(!mac_valid, "R1 mac_valid at reset", int'(mac_valid), 0);
    chk(fill_units == 0, "R1 fill at reset", int'(fill_units), 0);
    chk(drop_count == 0 && !drop_flag, "R1 drop state at reset", int'(drop_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(src_ready, "R9 ready after reset", int'(src_ready), 1);

    // Table walk: store-then-release latency, hold, burst, gap, fill
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][0], VEC[v][1], vs, nr);
      chk(vs == 0, "R2 no valid while writing", vs, 0);
      chk(!mac_valid, "R2 valid low one edge after eof", int'(mac_valid), 0);
      chk(int'(fill_units) == VEC[v][0] / 256, "R8 fill after store", int'(fill_units), VEC[v][0] / 256);
      @(negedge clk);
      chk(mac_valid, "R2 valid after second edge", int'(mac_valid), 1);
      recv_frame(VEC[v][0], VEC[v][1], VEC[v][2], w);
      chk(fill_units == 0, "R8 fill after drain", int'(fill_units), 0);
    end

    // R8: partial frame counts toward fill
    for (int i = 0; i < 600; i++) begin
      src_data = pat(20, i); src_sof = (i == 0); src_eof = (i == 599); src_valid = 1'b1;
      @(negedge clk);
      if (i == 299) chk(fill_units == 1, "R8 fill counts partial frame", int'(fill_units), 1);
    end
    src_valid = 1'b0; src_sof = 1'b0; src_eof = 1'b0;
    chk(fill_units == 2, "R8 fill after 600 bytes", int'(fill_units), 2);
    recv_frame(600, 20, 0, w);

    // R10 / R7: two queued frames in order, one-cycle gap
    send_frame(20, 30, vs, nr);
    send_frame(30, 31, vs, nr);
    recv_frame(20, 30, 1, w);
    @(negedge clk);
    chk(mac_valid && mac_data == pat(31, 0), "R7 next frame after one gap cycle", int'(mac_valid), 1);
    recv_frame(30, 31, 0, w);
    chk(w == 0, "R10 second frame delivered in order", w, 0);

    // R3 / R4 / R9: oversized frame into an empty buffer
    send_frame(4100, 40, vs, nr);
    chk(nr == 0, "R9 ready held during oversized frame", nr, 0);
    chk(vs == 0, "R3 dropped frame never offered", vs, 0);
    chk(drop_flag && drop_count == 1, "R3 drop flag and count", int'(drop_count), 1);
    chk(fill_units == 0, "R4 fill rolled back", int'(fill_units), 0);
    @(negedge clk);
    chk(!drop_flag && !mac_valid, "R3 drop flag one cycle, nothing offered", int'(drop_flag), 0);
    send_frame(20, 41, vs, nr);
    recv_frame(20, 41, 0, w);

    // R4: oversized frame behind a stored frame
    send_frame(600, 50, vs, nr);
    send_frame(4000, 51, vs, nr);
    chk(drop_count == 2, "R3 second drop counted", int'(drop_count), 2);
    chk(fill_units == 2, "R4 fill back to stored frame", int'(fill_units), 2);
    recv_frame(600, 50, 2, w);

    // R3: drop counter wraps
    send_frame(3000, 60, vs, nr);
    for (int d = 0; d < 16; d++) begin
      send_frame(1200, 61 + d, vs, nr);
      if (d == 13) chk(drop_count == 0, "R3 drop count wraps to 0", int'(drop_count), 0);
    end
    chk(drop_count == 2, "R3 drop count after 16 more drops", int'(drop_count), 2);
    chk(fill_units == 11, "R4 fill unchanged by drops", int'(fill_units), 11);
    recv_frame(3000, 60, 0, w);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule